// File: doc/BRIEF.md
# Sequential Next-Block Prefetch Generator

This block turns cache trigger events into a short stream of sequential prefetch requests. A trigger carries a block address and a flag. The flag says whether the event is a demand miss, from a load or a store, or the first touch of a block that an earlier prefetch brought in. On each trigger the block loads a block-address register and a count of requests still to send. It then offers the next consecutive block addresses on a valid/ready output, one per cycle.

The count comes from one of two sources. In the fixed policy, a miss asks for one block and a first touch asks for a larger, parameterised number of blocks (four by default). In the external mode, the count is taken from a degree input, which an adaptive controller can drive. Any trigger replaces the burst that is running. Cache tags, the per-block prefetched marker and filtering of the output stream belong to neighbouring logic.

Top module: `seq_prefetch_burst`

## Requirements
- R1: After reset, `pf_valid` and `busy` are 0.
- R2: In fixed mode (`mode_ext`=0), a trigger with `trig_is_reuse`=0 (demand miss) produces exactly one prefetch address, `trig_blk`+1.
- R3: In fixed mode, a trigger with `trig_is_reuse`=1 (first touch of a prefetched block) produces FIRST_USE_DEG addresses (default 4): `trig_blk`+1 up to `trig_blk`+FIRST_USE_DEG.
- R4: At most one address is handed over per cycle. Each accepted address is followed by the address one greater, and the address wraps modulo 2^ADDR_W.
- R5: While `pf_valid`=1 and `pf_ready`=0 with no trigger, `pf_blk` and the number of addresses still to send are held.
- R6: A trigger during a burst drops the rest of that burst. The addresses that follow are those of the new trigger only.
- R7: In external mode (`mode_ext`=1), the burst length equals `ext_degree`, clamped to MAX_DEG (default 64). A degree of 0 emits nothing.
- R8: `busy` is 1 exactly while addresses remain to be sent, which is whenever `pf_valid` is 1.
- R9: The first address of a burst is offered in the cycle right after the clock edge that samples the trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_valid | input | 1 | Trigger event present this cycle |
| trig_is_reuse | input | 1 | 1: first touch of a prefetched block; 0: demand miss |
| trig_blk | input | ADDR_W | Block address of the trigger |
| mode_ext | input | 1 | 1: burst length from `ext_degree`; 0: fixed policy |
| ext_degree | input | CNT_W | External burst length (clamped to MAX_DEG) |
| pf_valid | output | 1 | Prefetch address offered |
| pf_ready | input | 1 | Downstream accepts the offered address |
| pf_blk | output | ADDR_W | Prefetch block address |
| busy | output | 1 | Addresses remain to be sent |

## Verification
Demand misses and first-touch triggers in the fixed mode separate the two burst lengths. A trigger just below the top of the address space shows that the increment wraps. Holding ready low in the middle of a burst separates "hold" from "advance". A second trigger that lands one cycle into a four-block burst shows whether the old burst is dropped or carried on. In external mode, degrees of 7, 0 and 100 distinguish a plain load, the empty burst and the clamp at the maximum.

// File: rtl/seq_prefetch_burst.sv
module seq_prefetch_burst #(
  parameter int ADDR_W        = 32,
  parameter int MAX_DEG       = 64,
  parameter int FIRST_USE_DEG = 4,
  localparam int CNT_W        = $clog2(MAX_DEG + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_valid,
  input  logic              trig_is_reuse,
  input  logic [ADDR_W-1:0] trig_blk,
  input  logic              mode_ext,
  input  logic [CNT_W-1:0]  ext_degree,
  output logic              pf_valid,
  input  logic              pf_ready,
  output logic [ADDR_W-1:0] pf_blk,
  output logic              busy
);

  logic [ADDR_W-1:0] next_q;
  logic [CNT_W-1:0]  left_q;
  logic [CNT_W-1:0]  ext_deg;
  logic [CNT_W-1:0]  fix_deg;

  assign ext_deg = (ext_degree > CNT_W'(MAX_DEG)) ? CNT_W'(MAX_DEG) : ext_degree;
  assign fix_deg = trig_is_reuse ? CNT_W'(FIRST_USE_DEG) : CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      next_q <= '0;
      left_q <= '0;
    end else if (trig_valid) begin
      next_q <= trig_blk + ADDR_W'(1);
      left_q <= mode_ext ? ext_deg : fix_deg;
    end else if (pf_valid && pf_ready) begin
      next_q <= next_q + ADDR_W'(1);
      left_q <= left_q - CNT_W'(1);
    end
  end

  assign pf_valid = (left_q != '0);
  assign busy     = pf_valid;
  assign pf_blk   = next_q;

endmodule

// File: rtl/seq_prefetch_burst_chk.sv
module seq_prefetch_burst_chk #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              trig_valid,
  input logic              trig_is_reuse,
  input logic [ADDR_W-1:0] trig_blk,
  input logic              mode_ext,
  input logic [CNT_W-1:0]  ext_degree,
  input logic              pf_valid,
  input logic              pf_ready,
  input logic [ADDR_W-1:0] pf_blk,
  input logic              busy
);

  p_first_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_valid && !mode_ext) |=> (pf_valid && pf_blk == ADDR_W'($past(trig_blk) + 1)));

  p_miss_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_valid && !mode_ext && !trig_is_reuse) |=> busy);

  p_stall_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid && !pf_ready && !trig_valid) |=> (pf_valid && $stable(pf_blk)));

  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid && pf_ready && !trig_valid) |=> (!pf_valid || pf_blk == ADDR_W'($past(pf_blk) + 1)));

  p_zero_deg_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_valid && mode_ext && ext_degree == '0) |=> !pf_valid);

  p_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy == pf_valid);

endmodule

bind seq_prefetch_burst seq_prefetch_burst_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .trig_valid(trig_valid), .trig_is_reuse(trig_is_reuse),
  .trig_blk(trig_blk), .mode_ext(mode_ext), .ext_degree(ext_degree),
  .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_blk(pf_blk), .busy(busy)
);

// File: tb/test_seq_prefetch_burst.sv
module test_seq_prefetch_burst;
  localparam int AW = 32;
  localparam int CW = 7;

  logic clk = 0, rst_n = 0;
  logic trig_valid = 0, trig_is_reuse = 0, mode_ext = 0, pf_ready = 1;
  logic [AW-1:0] trig_blk = '0;
  logic [CW-1:0] ext_degree = '0;
  logic pf_valid, busy;
  logic [AW-1:0] pf_blk;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [AW-1:0] got[$];
  int m_left = 0;
  logic [AW-1:0] m_next = '0;

  always #4 clk = ~clk;

  seq_prefetch_burst i_seq_prefetch_burst (
    .clk(clk), .rst_n(rst_n), .trig_valid(trig_valid), .trig_is_reuse(trig_is_reuse),
    .trig_blk(trig_blk), .mode_ext(mode_ext), .ext_degree(ext_degree),
    .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_blk(pf_blk), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural reference and acceptance log
  always @(posedge clk) begin
    if (rst_n) begin
      if (pf_valid && pf_ready) got.push_back(pf_blk);
      if (trig_valid) begin
        m_next = trig_blk + 1;
        if (mode_ext) m_left = (int'(ext_degree) > 64) ? 64 : int'(ext_degree);
        else m_left = trig_is_reuse ? 4 : 1;
      end else if (m_left > 0 && pf_ready) begin
        m_next = m_next + 1;
        m_left = m_left - 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(pf_valid == (m_left > 0), "R8 valid vs model", pf_valid, m_left > 0);
      check(busy == (m_left > 0), "R8 busy vs model", busy, m_left > 0);
      if (m_left > 0) check(pf_blk == m_next, "R4 address vs model", pf_blk, m_next);
    end
  end

  task automatic trig(input logic [AW-1:0] a, input bit reuse, input bit ext, input int deg);
    trig_valid = 1; trig_blk = a; trig_is_reuse = reuse; mode_ext = ext; ext_degree = CW'(deg);
    @(negedge clk);
    trig_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_seq(input logic [AW-1:0] first, input int n, input string req);
    check(got.size() == n, req, got.size(), n);
    for (int i = 0; i < n && i < got.size(); i++)
      check(got[i] == AW'(first + i), req, got[i], AW'(first + i));
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin
    idle(2);
    check(pf_valid == 0, "R1 valid after reset", pf_valid, 0);
    check(busy == 0, "R1 busy after reset", busy, 0);
    rst_n = 1;
    idle(2);
    check(pf_valid == 0 && busy == 0, "R1 idle after release", pf_valid, 0);

    got.delete();
    trig(32'h1000, 0, 0, 0);
    check(pf_valid && pf_blk == 32'h1001, "R9 first address next cycle", pf_blk, 32'h1001);
    idle(6);
    expect_seq(32'h1001, 1, "R2 miss burst");

    got.delete();
    trig(32'h2000, 1, 0, 0);
    idle(8);
    expect_seq(32'h2001, 4, "R3 first-use burst");

    got.delete();
    trig(32'hFFFF_FFFE, 1, 0, 0);
    idle(8);
    expect_seq(32'hFFFF_FFFF, 4, "R4 wrap");

    got.delete();
    pf_ready = 0;
    trig(32'h3000, 1, 0, 0);
    idle(5);
    check(pf_valid && pf_blk == 32'h3001, "R5 held address", pf_blk, 32'h3001);
    check(got.size() == 0, "R5 nothing accepted", got.size(), 0);
    pf_ready = 1;
    idle(8);
    expect_seq(32'h3001, 4, "R5 burst after stall");

    got.delete();
    trig(32'h4000, 1, 0, 0);
    trig(32'h5000, 0, 0, 0);
    idle(8);
    check(got.size() == 2, "R6 reprogram count", got.size(), 2);
    if (got.size() == 2) begin
      check(got[0] == 32'h4001, "R6 old first", got[0], 32'h4001);
      check(got[1] == 32'h5001, "R6 new first", got[1], 32'h5001);
    end

    got.delete();
    trig(32'h6000, 0, 1, 7);
    check(busy == 1, "R8 busy during burst", busy, 1);
    idle(10);
    expect_seq(32'h6001, 7, "R7 external degree 7");

    got.delete();
    trig(32'h7000, 1, 1, 0);
    check(pf_valid == 0 && busy == 0, "R7 degree zero idle", pf_valid, 0);
    idle(4);
    check(got.size() == 0, "R7 degree zero emits nothing", got.size(), 0);

    got.delete();
    trig(32'h8000, 0, 1, 100);
    idle(70);
    expect_seq(32'h8001, 64, "R7 clamp to maximum");
    check(busy == 0, "R8 busy clear after burst", busy, 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule